// File: doc/BRIEF.md
# Bit-Serial Binary-to-Gray Encoder

This block turns binary words into reflected Gray code one bit per clock, most significant bit first. A word opens with a start-of-word marker on its first bit. The encoder keeps one bit of history, the previous accepted input bit of the word, and forms each output bit with a single exclusive-OR. The Gray bit and its valid strobe come out combinationally, in the same cycle as the input bit. While a word is being encoded, a shift register collects the Gray bits. When the last bit goes through, a done pulse is raised and the whole Gray word is latched into a parallel output.

The word width is a parameter and defaults to 4. A clock-enable freezes all state during idle cycles. Gaps in the input valid strobe are also allowed in the middle of a word. A start-of-word that arrives in the middle of a word abandons the partial word and begins a new one. Reset is synchronous and active high.

Top module: `gray_serial_enc`

## Requirements
- R1: A bit accepted with `in_sow` high starts a word, and its output bit equals the input bit (the most significant Gray bit is the binary MSB).
- R2: Every later bit of a word produces `out_bit` equal to `in_bit` XOR the previous accepted input bit of the same word.
- R3: A bit is accepted when `en`, `in_valid` and either `in_sow` or an open word are all present. `out_valid` is high in exactly those cycles. A bit with `in_sow` low while no word is open gives `out_valid` low and changes nothing.
- R4: `done` is high in the same cycle as the WIDTH-th accepted bit of a word and at no other time.
- R5: In the cycle after `done`, `par_word` holds the Gray code of the word (binary w gives w XOR (w >> 1)), with the MSB at bit WIDTH-1. At all other times it holds its value.
- R6: A start-of-word in the middle of a word abandons the partial word, so no `done` is raised for it, and the new word counts from that bit.
- R7: While `en` is low, `out_valid` and `done` are low and all state is held, so a word split by enable-low cycles encodes the same as a word sent without gaps.
- R8: While `rst` is high, `out_valid` and `done` are low. After reset, `par_word` is 0 and no word is open.
- R9: Consecutive binary values give Gray words on `par_word` that differ in exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock-enable; low holds all state |
| in_bit | input | 1 | Serial binary data bit, MSB first |
| in_valid | input | 1 | Input bit strobe |
| in_sow | input | 1 | Marks the first bit of a word |
| out_bit | output | 1 | Serial Gray bit |
| out_valid | output | 1 | Output bit strobe |
| par_word | output | WIDTH | Last completed Gray word |
| done | output | 1 | High on the cycle of the last bit of a word |

## Verification
All sixteen 4-bit words are sent in ascending order. This covers the all-zero word, the all-ones word and the alternating words, and it shows whether each XOR pairs the correct neighbours. Comparing adjacent results also checks the single-bit-change property. Random words are sent with random gaps of both kinds: enable-low cycles and valid-low cycles. These tell a correct hold of the history bit and counter apart from logic that advances on a dead cycle. Directed cases cover a word abandoned by an early start-of-word and a stray bit with no open word, which separate the correct restart from a counter that keeps running or accepts unframed data.

// File: rtl/gse_pkg.sv
package gse_pkg;
    // One Gray bit: the first bit of a word passes through unchanged.
    function automatic logic gse_code_bit(logic b, logic hist, logic first);
        return b ^ (hist & ~first);
    endfunction
endpackage

// File: rtl/gse_framer.sv
module gse_framer #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic in_valid,
    input  logic in_sow,
    output logic accept,
    output logic first,
    output logic last
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [CW-1:0] idx;

    always_comb begin
        frm_d  = frm_q;
        accept = en & ~rst & in_valid & (in_sow | frm_q.active);
        first  = accept & in_sow;
        idx    = in_sow ? '0 : frm_q.cnt;
        last   = accept & (idx == LAST_IDX);
        if (accept) begin
            frm_d.active = ~last;
            frm_d.cnt    = last ? '0 : idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end
endmodule

// File: rtl/gse_xor_cell.sv
module gse_xor_cell (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic first,
    input  logic in_bit,
    output logic gbit
);
    import gse_pkg::*;

    logic hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        gbit   = gse_code_bit(in_bit, hist_q, first);
        if (accept) begin
            hist_d = in_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/gse_shifter.sv
module gse_shifter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             last,
    input  logic             gbit,
    output logic [WIDTH-1:0] par_word
);
    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [WIDTH-1:0] par;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (accept) begin
            shf_d.sh = {shf_q.sh[WIDTH-2:0], gbit};
        end
        if (last) begin
            shf_d.par = {shf_q.sh[WIDTH-2:0], gbit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign par_word = shf_q.par;
endmodule

// File: rtl/gray_serial_enc.sv
module gray_serial_enc #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             in_bit,
    input  logic             in_valid,
    input  logic             in_sow,
    output logic             out_bit,
    output logic             out_valid,
    output logic [WIDTH-1:0] par_word,
    output logic             done
);
    logic accept, first, last, gbit;

    gse_framer #(.WIDTH(WIDTH)) u_framer (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_sow(in_sow),
        .accept(accept), .first(first), .last(last)
    );

    gse_xor_cell u_xor (
        .clk(clk), .rst(rst), .accept(accept), .first(first),
        .in_bit(in_bit), .gbit(gbit)
    );

    gse_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk(clk), .rst(rst), .accept(accept), .last(last),
        .gbit(gbit), .par_word(par_word)
    );

    assign out_bit   = gbit;
    assign out_valid = accept;
    assign done      = last;
endmodule

// File: rtl/gse_checker.sv
module gse_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             in_bit,
    input logic             in_valid,
    input logic             in_sow,
    input logic             out_bit,
    input logic             out_valid,
    input logic [WIDTH-1:0] par_word,
    input logic             done
);
    a_r1_msb_passes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_sow) |-> (out_bit == in_bit));

    a_r4_done_with_bit: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid);

    a_r5_par_holds: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(par_word));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!out_valid && !done));

    a_r3_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !out_valid);

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (par_word == '0));
endmodule

bind gray_serial_enc gse_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_gray_serial_enc.sv
module sim_gray_serial_enc;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst, en, in_bit, in_valid, in_sow;
    logic out_bit, out_valid, done;
    logic [W-1:0] par_word;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    gray_serial_enc #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .en(en), .in_bit(in_bit), .in_valid(in_valid),
        .in_sow(in_sow), .out_bit(out_bit), .out_valid(out_valid),
        .par_word(par_word), .done(done)
    );

    function automatic logic [W-1:0] to_gray(logic [W-1:0] w);
        return w ^ (w >> 1);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_cycles(int n, bit use_en);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_bit   = 1'($urandom);
            in_sow   = 1'b0;
            if (use_en) begin en = 1'b0; in_valid = 1'b1; end
            else begin en = 1'b1; in_valid = 1'b0; end
            #1;
            chk(!out_valid && !done, use_en ? "R7 idle enable" : "R3 no valid",
                {out_valid, done}, 0);
        end
    endtask

    task automatic send_bit(logic b, logic sow);
        @(negedge clk);
        en = 1'b1; in_valid = 1'b1; in_sow = sow; in_bit = b;
        #1;
    endtask

    task automatic release_in;
        @(negedge clk);
        in_valid = 1'b0; in_sow = 1'b0; en = 1'b1;
        #1;
    endtask

    task automatic run_word(logic [W-1:0] w, bit gaps);
        logic [W-1:0] g;
        g = to_gray(w);
        for (int i = W - 1; i >= 0; i--) begin
            if (gaps && i != W - 1) idle_cycles(int'($urandom_range(0, 2)), 1'($urandom));
            send_bit(w[i], i == W - 1);
            chk(out_valid, "R3 out_valid", out_valid, 1);
            chk(out_bit == g[i], (i == W - 1) ? "R1 msb" : "R2 xor bit", out_bit, g[i]);
            chk(done == (i == 0), "R4 done", done, (i == 0));
        end
        release_in();
        chk(par_word == g, gaps ? "R7 gapped word" : "R5 par_word", par_word, g);
    endtask

    initial begin
        logic [W-1:0] prev, held;
        void'($urandom(32'd1234));
        rst = 1'b1; en = 1'b1; in_valid = 1'b1; in_sow = 1'b1; in_bit = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !done, "R8 outputs in reset", {out_valid, done}, 0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0; in_sow = 1'b0;
        #1;
        chk(par_word == 0, "R8 par after reset", par_word, 0);

        // stray bit with no open word
        send_bit(1'b1, 1'b0);
        chk(!out_valid && !done, "R3 stray bit", {out_valid, done}, 0);
        release_in();
        chk(par_word == 0, "R3 stray par", par_word, 0);

        // all 16 words, ascending, with adjacency check
        for (int v = 0; v < 16; v++) begin
            run_word(W'(v), 1'b0);
            if (v > 0) chk($countones(par_word ^ prev) == 1, "R9 one bit change",
                           par_word ^ prev, 1);
            prev = par_word;
        end

        // abort: partial word then a fresh word
        held = par_word;
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        chk(!done, "R6 no done on partial", done, 0);
        send_bit(1'b1, 1'b0);
        chk(!done, "R6 no done on partial", done, 0);
        release_in();
        chk(par_word == held, "R6 par held after abort", par_word, held);
        send_bit(1'b0, 1'b1);
        chk(!done, "R6 no done before restart", done, 0);
        run_word(4'b0110, 1'b0);
        chk(par_word == to_gray(4'b0110), "R6 restarted word", par_word, to_gray(4'b0110));

        // random words with gaps
        for (int n = 0; n < 60; n++) begin
            run_word(W'($urandom), 1'b1);
            if (($urandom & 3) == 0) idle_cycles(2, 1'b0);
        end

        // reset mid-word
        send_bit(1'b1, 1'b1);
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
        #1;
        chk(par_word == 0, "R8 par after mid reset", par_word, 0);
        send_bit(1'b1, 1'b0);
        chk(!out_valid, "R8 no open word after reset", out_valid, 0);
        release_in();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule